// File: doc/BRIEF.md
# Integer Operate Unit with Conditional Move

This block carries out the integer operate-format instructions of a 64-bit processor. These are longword and quadword add and subtract, add and subtract with operand A scaled by 4 or by 8, equality and ordered compares, the six bitwise logic forms, and the eight conditional moves. The issue stage presents a 32-bit instruction word and the two values already read from the register file. One clock later the block returns four things: the destination register number, a write-enable, the 64-bit value to write, and a flag for an instruction it does not recognise.

Operand B is either the second register value or an 8-bit literal taken from the instruction and zero-extended. Bit 12 of the instruction selects between them. Two cases produce no write at all: a conditional move whose test fails, and a result aimed at register 31. In both cases write-enable stays low and the result bus is zero, so the register file keeps the value it already holds.

Top module: `int_op_alu`

## Requirements
- R1: After a synchronous reset, and in the cycle after any cycle in which reset is held, the outputs read write-enable 0, illegal 0, result 0 and destination 0.
- R2: Instruction bit 12 set selects operand B as the literal in bits 20:13, zero-extended to 64 bits, in place of the B register value. Bit 12 clear uses the B register value.
- R3: The longword add (opcode 0x10, function 0x00) adds the low 32 bits of A and B and sign-extends the 32-bit sum to 64 bits. The upper halves of the operands have no effect.
- R4: Opcode 0x10 arithmetic uses these function codes: 0x20 gives A+B, 0x29 gives A−B, 0x22 gives 4A+B, 0x2B gives 4A−B, 0x32 gives 8A+B, and 0x3B gives 8A−B. All arithmetic wraps modulo 2^64.
- R5: Opcode 0x10 compares write 1 when the test holds and 0 otherwise. The function codes are 0x2D for A equal to B, 0x1D for unsigned A<B, 0x3D for unsigned A≤B, 0x4D for signed A<B, and 0x6D for signed A≤B.
- R6: Opcode 0x11 logic uses these function codes: 0x00 gives A AND B, 0x08 gives A AND NOT B, 0x20 gives A OR B, 0x28 gives A OR NOT B, 0x40 gives A XOR B, and 0x48 gives A XOR NOT B.
- R7: An opcode 0x11 conditional move writes B only when its test on A holds. The function codes are 0x14 for bit 0 set, 0x16 for bit 0 clear, 0x24 for A zero, 0x26 for A nonzero, 0x44 for A negative, 0x46 for A non-negative, 0x64 for A at most zero, and 0x66 for A above zero. A failed test gives write-enable 0 and result 0.
- R8: A destination field (bits 4:0) of 31 gives write-enable 0 and result 0 for every operation.
- R9: An unknown function code under opcode 0x10 or 0x11, or any opcode (bits 31:26) other than these two, raises illegal and gives write-enable 0 and result 0.
- R10: The outputs are registered with one cycle of latency. The destination output equals bits 4:0 of the instruction presented in the previous cycle, and the outputs do not change between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Operate-format instruction word |
| ra_val_i | input | 64 | Value of register A |
| rb_val_i | input | 64 | Value of register B |
| rc_o | output | 5 | Destination register number |
| we_o | output | 1 | Register write-enable |
| result_o | output | 64 | Value to write |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
The adds use operands chosen to expose specific faults. A low-word sum that crosses into bit 31 shows whether sign extension happens, and operands with garbage in the upper halves show whether the upper word leaks into the longword add. The scaled forms use operand pairs whose results differ for every wrong shift amount and for a swapped add or subtract. The compares pair 1 with all-ones, which separates the signed and unsigned orderings. Each conditional move is tried once with its test true and once with it false, and the literal path uses a literal with bit 7 set to expose any sign extension.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam logic [5:0] OPC_ARITH = 6'h10;
  localparam logic [5:0] OPC_LOGIC = 6'h11;

  localparam logic [6:0] FN_ADDL   = 7'h00;
  localparam logic [6:0] FN_ADDQ   = 7'h20;
  localparam logic [6:0] FN_SUBQ   = 7'h29;
  localparam logic [6:0] FN_ADD4   = 7'h22;
  localparam logic [6:0] FN_SUB4   = 7'h2B;
  localparam logic [6:0] FN_ADD8   = 7'h32;
  localparam logic [6:0] FN_SUB8   = 7'h3B;
  localparam logic [6:0] FN_CEQ    = 7'h2D;
  localparam logic [6:0] FN_CULT   = 7'h1D;
  localparam logic [6:0] FN_CULE   = 7'h3D;
  localparam logic [6:0] FN_CLT    = 7'h4D;
  localparam logic [6:0] FN_CLE    = 7'h6D;

  localparam logic [6:0] FN_AND    = 7'h00;
  localparam logic [6:0] FN_ANDN   = 7'h08;
  localparam logic [6:0] FN_OR     = 7'h20;
  localparam logic [6:0] FN_ORN    = 7'h28;
  localparam logic [6:0] FN_XOR    = 7'h40;
  localparam logic [6:0] FN_XNOR   = 7'h48;
  localparam logic [6:0] FN_MV_ODD = 7'h14;
  localparam logic [6:0] FN_MV_EVN = 7'h16;
  localparam logic [6:0] FN_MV_EQZ = 7'h24;
  localparam logic [6:0] FN_MV_NEZ = 7'h26;
  localparam logic [6:0] FN_MV_LTZ = 7'h44;
  localparam logic [6:0] FN_MV_GEZ = 7'h46;
  localparam logic [6:0] FN_MV_LEZ = 7'h64;
  localparam logic [6:0] FN_MV_GTZ = 7'h66;

  localparam logic [4:0] REG_ZERO  = 5'd31;

  typedef struct packed {
    logic [5:0] opc;
    logic [4:0] ra;
    logic [4:0] rb;
    logic       lit_sel;
    logic [6:0] fn;
    logic [4:0] rc;
  } op_fields_t;
endpackage

// File: rtl/ialu_decode.sv
module ialu_decode #(
  parameter int XLEN  = 64,
  parameter int LIT_W = 8,
  parameter int LIT_LO = 13
) (
  input  logic [31:0]          instr,
  input  logic [XLEN-1:0]      rb_val,
  output ialu_pkg::op_fields_t f,
  output logic [XLEN-1:0]      b_opnd
);
  logic [LIT_W-1:0] lit;

  assign f.opc     = instr[31:26];
  assign f.ra      = instr[25:21];
  assign f.rb      = instr[20:16];
  assign f.lit_sel = instr[12];
  assign f.fn      = instr[11:5];
  assign f.rc      = instr[4:0];

  assign lit    = instr[LIT_LO +: LIT_W];
  assign b_opnd = f.lit_sel ? {{(XLEN-LIT_W){1'b0}}, lit} : rb_val;
endmodule

// File: rtl/ialu_arith.sv
module ialu_arith #(
  parameter int XLEN = 64,
  parameter int LW   = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [6:0]      fn,
  output logic [XLEN-1:0] res,
  output logic            legal
);
  import ialu_pkg::*;

  localparam int EXT_W = XLEN - LW;

  logic [LW-1:0]   sum_lw;
  logic [XLEN-1:0] a4, a8, lw_ext;
  logic            ult, slt, eq;

  assign sum_lw = a[LW-1:0] + b[LW-1:0];
  assign a4     = a << 2;
  assign a8     = a << 3;
  assign eq     = (a == b);
  assign ult    = (a < b);
  assign slt    = ($signed(a) < $signed(b));

  generate
    if (EXT_W > 0) begin : g_ext
      assign lw_ext = {{EXT_W{sum_lw[LW-1]}}, sum_lw};
    end else begin : g_noext
      assign lw_ext = sum_lw[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    legal = 1'b1;
    res   = '0;
    case (fn)
      FN_ADDL: res = lw_ext;
      FN_ADDQ: res = a + b;
      FN_SUBQ: res = a - b;
      FN_ADD4: res = a4 + b;
      FN_SUB4: res = a4 - b;
      FN_ADD8: res = a8 + b;
      FN_SUB8: res = a8 - b;
      FN_CEQ:  res = {{(XLEN-1){1'b0}}, eq};
      FN_CULT: res = {{(XLEN-1){1'b0}}, ult};
      FN_CULE: res = {{(XLEN-1){1'b0}}, ult | eq};
      FN_CLT:  res = {{(XLEN-1){1'b0}}, slt};
      FN_CLE:  res = {{(XLEN-1){1'b0}}, slt | eq};
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ialu_logic.sv
module ialu_logic #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [6:0]      fn,
  output logic [XLEN-1:0] res,
  output logic            legal,
  output logic            is_mov,
  output logic            mov_ok
);
  import ialu_pkg::*;

  logic a_zero, a_neg;

  assign a_zero = (a == '0);
  assign a_neg  = a[XLEN-1];

  always_comb begin
    legal  = 1'b1;
    is_mov = 1'b0;
    mov_ok = 1'b0;
    res    = '0;
    case (fn)
      FN_AND:    res = a & b;
      FN_ANDN:   res = a & ~b;
      FN_OR:     res = a | b;
      FN_ORN:    res = a | ~b;
      FN_XOR:    res = a ^ b;
      FN_XNOR:   res = a ^ ~b;
      FN_MV_ODD: begin is_mov = 1'b1; res = b; mov_ok = a[0];               end
      FN_MV_EVN: begin is_mov = 1'b1; res = b; mov_ok = ~a[0];              end
      FN_MV_EQZ: begin is_mov = 1'b1; res = b; mov_ok = a_zero;             end
      FN_MV_NEZ: begin is_mov = 1'b1; res = b; mov_ok = ~a_zero;            end
      FN_MV_LTZ: begin is_mov = 1'b1; res = b; mov_ok = a_neg;              end
      FN_MV_GEZ: begin is_mov = 1'b1; res = b; mov_ok = ~a_neg;             end
      FN_MV_LEZ: begin is_mov = 1'b1; res = b; mov_ok = a_neg | a_zero;     end
      FN_MV_GTZ: begin is_mov = 1'b1; res = b; mov_ok = ~a_neg & ~a_zero;   end
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_op_alu.sv
module int_op_alu #(
  parameter int XLEN  = 64,
  parameter int LW    = 32,
  parameter int LIT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] ra_val_i,
  input  logic [XLEN-1:0] rb_val_i,
  output logic [4:0]      rc_o,
  output logic            we_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  import ialu_pkg::*;

  op_fields_t      fld;
  logic [XLEN-1:0] b_opnd;
  logic [XLEN-1:0] ar_res, lg_res, val;
  logic            ar_legal, lg_legal, lg_mov, lg_ok;
  logic            legal, write_ok, we_n;

  ialu_decode #(.XLEN(XLEN), .LIT_W(LIT_W)) u_dec (
    .instr (instr_i),
    .rb_val(rb_val_i),
    .f     (fld),
    .b_opnd(b_opnd)
  );

  ialu_arith #(.XLEN(XLEN), .LW(LW)) u_arith (
    .a    (ra_val_i),
    .b    (b_opnd),
    .fn   (fld.fn),
    .res  (ar_res),
    .legal(ar_legal)
  );

  ialu_logic #(.XLEN(XLEN)) u_logic (
    .a     (ra_val_i),
    .b     (b_opnd),
    .fn    (fld.fn),
    .res   (lg_res),
    .legal (lg_legal),
    .is_mov(lg_mov),
    .mov_ok(lg_ok)
  );

  always_comb begin
    legal    = 1'b0;
    write_ok = 1'b0;
    val      = '0;
    case (fld.opc)
      OPC_ARITH: begin
        legal    = ar_legal;
        write_ok = 1'b1;
        val      = ar_res;
      end
      OPC_LOGIC: begin
        legal    = lg_legal;
        write_ok = ~lg_mov | lg_ok;
        val      = lg_res;
      end
      default: ;
    endcase
  end

  assign we_n = legal & write_ok & (fld.rc != REG_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_o      <= '0;
      we_o      <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      rc_o      <= fld.rc;
      we_o      <= we_n;
      result_o  <= we_n ? val : '0;
      illegal_o <= ~legal;
    end
  end
endmodule

// File: rtl/int_op_alu_chk.sv
module int_op_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] ra_val_i,
  input logic [4:0]      rc_o,
  input logic            we_o,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  logic arith_op, cmp_op, addq_lit, nez_mov;

  assign arith_op = (instr_i[31:26] == 6'h10);
  assign cmp_op   = arith_op && (instr_i[11:5] == 7'h2D || instr_i[11:5] == 7'h1D ||
                                 instr_i[11:5] == 7'h3D || instr_i[11:5] == 7'h4D ||
                                 instr_i[11:5] == 7'h6D) && (instr_i[4:0] != 5'd31);
  assign addq_lit = arith_op && (instr_i[11:5] == 7'h20) && instr_i[12] &&
                    (instr_i[4:0] != 5'd31);
  assign nez_mov  = (instr_i[31:26] == 6'h11) && (instr_i[11:5] == 7'h26) &&
                    (ra_val_i == '0);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!we_o && !illegal_o && result_o == '0 && rc_o == '0));

  assert_literal_zext_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addq_lit)) |->
      (result_o == $past(ra_val_i) + {{(XLEN-8){1'b0}}, $past(instr_i[20:13])}));

  assert_cmp_boolean_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmp_op)) |-> (we_o && result_o[XLEN-1:1] == '0));

  assert_failed_move_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(nez_mov)) |-> (!we_o && result_o == '0));

  assert_no_zero_reg_write_R8: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (rc_o != 5'd31));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!we_o && result_o == '0));

  assert_dest_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rc_o == $past(instr_i[4:0])));
endmodule

bind int_op_alu int_op_alu_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .instr_i  (instr_i),
  .ra_val_i (ra_val_i),
  .rc_o     (rc_o),
  .we_o     (we_o),
  .result_o (result_o),
  .illegal_o(illegal_o)
);

// File: tb/int_op_alu_tb.sv
module int_op_alu_tb;
  localparam int XLEN = 64;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [7:0]  req;
    logic [5:0]  op;
    logic [6:0]  fn;
    logic        le;
    logic [7:0]  lit;
    logic [4:0]  rc;
    logic [63:0] a;
    logic [63:0] b;
    logic        we;
    logic        ill;
    logic [63:0] res;
  } vec_t;

  localparam int N = 38;
  localparam vec_t TBL [N] = '{
    // R3 longword add, sign extension and ignored upper halves
    '{8'd3, 6'h10, 7'h00, 1'b0, 8'h00, 5'd3, 64'h7FFF_FFFF, 64'h1, 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000},
    '{8'd3, 6'h10, 7'h00, 1'b0, 8'h00, 5'd4, 64'hAAAA_0000_0000_0001, 64'h5555_0000_0000_0002, 1'b1, 1'b0, 64'h3},
    // R4 quadword and scaled arithmetic
    '{8'd4, 6'h10, 7'h20, 1'b0, 8'h00, 5'd5, 64'h5, 64'h7, 1'b1, 1'b0, 64'hC},
    '{8'd4, 6'h10, 7'h29, 1'b0, 8'h00, 5'd6, 64'h5, 64'h7, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE},
    '{8'd4, 6'h10, 7'h22, 1'b0, 8'h00, 5'd7, 64'h3, 64'h1, 1'b1, 1'b0, 64'hD},
    '{8'd4, 6'h10, 7'h2B, 1'b0, 8'h00, 5'd8, 64'h3, 64'h1, 1'b1, 1'b0, 64'hB},
    '{8'd4, 6'h10, 7'h32, 1'b0, 8'h00, 5'd9, 64'h3, 64'h1, 1'b1, 1'b0, 64'h19},
    '{8'd4, 6'h10, 7'h3B, 1'b0, 8'h00, 5'd10, 64'h3, 64'h1E, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFA},
    // R2 literal operand, zero-extended
    '{8'd2, 6'h10, 7'h20, 1'b1, 8'hFF, 5'd11, 64'h1, 64'h3E8, 1'b1, 1'b0, 64'h100},
    '{8'd2, 6'h10, 7'h29, 1'b1, 8'h80, 5'd12, 64'h100, 64'h3E8, 1'b1, 1'b0, 64'h80},
    // R5 compares
    '{8'd5, 6'h10, 7'h2D, 1'b0, 8'h00, 5'd13, 64'h5, 64'h5, 1'b1, 1'b0, 64'h1},
    '{8'd5, 6'h10, 7'h2D, 1'b0, 8'h00, 5'd14, 64'h5, 64'h6, 1'b1, 1'b0, 64'h0},
    '{8'd5, 6'h10, 7'h1D, 1'b0, 8'h00, 5'd15, 64'h1, ONES, 1'b1, 1'b0, 64'h1},
    '{8'd5, 6'h10, 7'h4D, 1'b0, 8'h00, 5'd16, 64'h1, ONES, 1'b1, 1'b0, 64'h0},
    '{8'd5, 6'h10, 7'h3D, 1'b0, 8'h00, 5'd17, 64'h7, 64'h7, 1'b1, 1'b0, 64'h1},
    '{8'd5, 6'h10, 7'h6D, 1'b0, 8'h00, 5'd18, ONES, 64'h0, 1'b1, 1'b0, 64'h1},
    // R6 logic
    '{8'd6, 6'h11, 7'h00, 1'b0, 8'h00, 5'd19, 64'hF0F0, 64'hFF00, 1'b1, 1'b0, 64'hF000},
    '{8'd6, 6'h11, 7'h08, 1'b0, 8'h00, 5'd20, 64'hFF, 64'h0F, 1'b1, 1'b0, 64'hF0},
    '{8'd6, 6'h11, 7'h20, 1'b0, 8'h00, 5'd21, 64'hF0, 64'h0F, 1'b1, 1'b0, 64'hFF},
    '{8'd6, 6'h11, 7'h28, 1'b0, 8'h00, 5'd22, 64'h0, 64'hFFFF_FFFF_FFFF_FF00, 1'b1, 1'b0, 64'hFF},
    '{8'd6, 6'h11, 7'h40, 1'b0, 8'h00, 5'd23, 64'hFF, 64'h0F, 1'b1, 1'b0, 64'hF0},
    '{8'd6, 6'h11, 7'h48, 1'b0, 8'h00, 5'd24, 64'h0, 64'h0, 1'b1, 1'b0, ONES},
    // R7 conditional moves, test true and false
    '{8'd7, 6'h11, 7'h14, 1'b0, 8'h00, 5'd25, 64'h1, 64'h55, 1'b1, 1'b0, 64'h55},
    '{8'd7, 6'h11, 7'h14, 1'b0, 8'h00, 5'd25, 64'h2, 64'h55, 1'b0, 1'b0, 64'h0},
    '{8'd7, 6'h11, 7'h16, 1'b0, 8'h00, 5'd26, 64'h2, 64'h55, 1'b1, 1'b0, 64'h55},
    '{8'd7, 6'h11, 7'h24, 1'b0, 8'h00, 5'd27, 64'h0, 64'h55, 1'b1, 1'b0, 64'h55},
    '{8'd7, 6'h11, 7'h26, 1'b0, 8'h00, 5'd28, 64'h0, 64'h55, 1'b0, 1'b0, 64'h0},
    '{8'd7, 6'h11, 7'h44, 1'b0, 8'h00, 5'd29, ONES, 64'h55, 1'b1, 1'b0, 64'h55},
    '{8'd7, 6'h11, 7'h46, 1'b0, 8'h00, 5'd30, ONES, 64'h55, 1'b0, 1'b0, 64'h0},
    '{8'd7, 6'h11, 7'h64, 1'b0, 8'h00, 5'd1, 64'h0, 64'h55, 1'b1, 1'b0, 64'h55},
    '{8'd7, 6'h11, 7'h66, 1'b0, 8'h00, 5'd2, 64'h0, 64'h55, 1'b0, 1'b0, 64'h0},
    '{8'd7, 6'h11, 7'h66, 1'b0, 8'h00, 5'd2, 64'h5, 64'h55, 1'b1, 1'b0, 64'h55},
    // R8 destination 31
    '{8'd8, 6'h10, 7'h20, 1'b0, 8'h00, 5'd31, 64'h5, 64'h7, 1'b0, 1'b0, 64'h0},
    '{8'd8, 6'h11, 7'h24, 1'b0, 8'h00, 5'd31, 64'h0, 64'h55, 1'b0, 1'b0, 64'h0},
    // R9 unknown codes and opcodes
    '{8'd9, 6'h10, 7'h01, 1'b0, 8'h00, 5'd3, 64'h5, 64'h7, 1'b0, 1'b1, 64'h0},
    '{8'd9, 6'h11, 7'h01, 1'b0, 8'h00, 5'd3, 64'h5, 64'h7, 1'b0, 1'b1, 64'h0},
    '{8'd9, 6'h12, 7'h00, 1'b0, 8'h00, 5'd3, 64'h5, 64'h7, 1'b0, 1'b1, 64'h0},
    // R2 with R6: literal into logic
    '{8'd2, 6'h11, 7'h20, 1'b1, 8'h5A, 5'd4, 64'hA500, ONES, 1'b1, 1'b0, 64'hA55A}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] ra_val_i = '0;
  logic [XLEN-1:0] rb_val_i = '0;
  logic [4:0]      rc_o;
  logic            we_o;
  logic [XLEN-1:0] result_o;
  logic            illegal_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  int_op_alu #(.XLEN(XLEN)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .instr_i  (instr_i),
    .ra_val_i (ra_val_i),
    .rb_val_i (rb_val_i),
    .rc_o     (rc_o),
    .we_o     (we_o),
    .result_o (result_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [6:0] fn,
                                      input logic le, input logic [7:0] lit,
                                      input logic [4:0] rc);
    if (le) return {op, 5'd1, lit, 1'b1, fn, rc};
    return {op, 5'd1, 5'd2, 3'b000, 1'b0, fn, rc};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [4:0] rc,
                           input logic we, input logic ill, input logic [63:0] res);
    check(req, "dest (R10)", {59'd0, rc_o}, {59'd0, rc});
    check(req, "we", {63'd0, we_o}, {63'd0, we});
    check(req, "illegal", {63'd0, illegal_o}, {63'd0, ill});
    check(req, "result", result_o, res);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1", 5'd0, 1'b0, 1'b0, 64'h0);
    rst = 1'b0;

    foreach (TBL[i]) begin
      instr_i  = enc(TBL[i].op, TBL[i].fn, TBL[i].le, TBL[i].lit, TBL[i].rc);
      ra_val_i = TBL[i].a;
      rb_val_i = TBL[i].b;
      @(negedge clk);
      check_all($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].rc,
                TBL[i].we, TBL[i].ill, TBL[i].res);
    end

    // R10 outputs hold until the next edge
    instr_i  = enc(6'h10, 7'h20, 1'b0, 8'h00, 5'd9);
    ra_val_i = 64'h10;
    rb_val_i = 64'h20;
    @(negedge clk);
    check_all("R10 first", 5'd9, 1'b1, 1'b0, 64'h30);
    instr_i  = enc(6'h10, 7'h29, 1'b0, 8'h00, 5'd7);
    ra_val_i = 64'h40;
    rb_val_i = 64'h1;
    #2;
    check_all("R10 hold", 5'd9, 1'b1, 1'b0, 64'h30);
    @(negedge clk);
    check_all("R10 update", 5'd7, 1'b1, 1'b0, 64'h3F);

    // R1 reset during operation
    rst = 1'b1;
    @(negedge clk);
    check_all("R1 midrun", 5'd0, 1'b0, 1'b0, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 release", 5'd7, 1'b1, 1'b0, 64'h3F);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule